// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the pending-interrupt flags and the per-source enable bits for two timer/counters, and it picks which timer request goes to the processor. Four single-cycle event pulses come in from the counters: counter-1 overflow, counter-1 compare match A, counter-1 input capture and counter-0 overflow. In PWM operation the counter logic sends its change of direction at zero on the counter-1 overflow input. Each pulse sets a sticky flag.

Software reaches the two registers, the enable mask and the flag register, through a small register port. Writes take effect at the clock edge, and reads are combinational. A flag clears in one of two ways. Software can write a one to its bit, or the processor can acknowledge the vector that belongs to that flag. A request goes out only when the global interrupt enable, the flag's enable bit and the flag itself are all one. When several requests are pending, the one with the lowest vector number is presented.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every flag and every enable bit is zero, both registers read 0x00 and `irq_req` is low.
- R2: One clock after an event pulse, its flag reads as one. The flag bit positions are: capture at bit 3, compare A at bit 6, counter-1 overflow at bit 7 and counter-0 overflow at bit 1.
- R3: Writing to the flag register (`bus_sel`=1) clears each flag whose written bit is one. Flags whose written bit is zero keep their value.
- R4: Bits 5, 4, 2 and 0 of the flag register and of the mask register always read zero, and writes to them have no effect.
- R5: Mask bits 7, 6, 3 and 1 enable counter-1 overflow, compare A, capture and counter-0 overflow respectively. A write with `bus_sel`=0 stores them, and they read back unchanged.
- R6: `irq_req` is high only when `gie` is one and some flag is one together with its enable bit. Otherwise `irq_req` is low and `irq_vec` is 0.
- R7: The vector numbers are: capture 3, compare A 4, counter-1 overflow 5, counter-0 overflow 6.
- R8: When more than one enabled flag is pending, `irq_vec` is the lowest of their vector numbers.
- R9: An `ack_valid` pulse clears, at the next clock, only the flag whose vector equals `ack_vec`. A vector that matches no source changes nothing.
- R10: If an event pulse and a clear (by write or by acknowledge) hit the same flag in the same cycle, the flag is one afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_cap | input | 1 | Counter-1 input capture event pulse |
| ev_cmpa | input | 1 | Counter-1 compare match A event pulse |
| ev_ovf1 | input | 1 | Counter-1 overflow / direction change at zero pulse |
| ev_ovf0 | input | 1 | Counter-0 overflow event pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 mask, 1 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| gie | input | 1 | Global interrupt enable |
| ack_valid | input | 1 | Processor acknowledges a vector |
| ack_vec | input | 3 | Vector being acknowledged |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 3 | Vector number of the presented request |

## Verification
On every clock the assertions check several rules. Each flag is set after its event and clears only when a clear arrives without an event. It holds its value when neither arrives. At most one source is granted. A request is never raised with `gie` low and always carries a vector between 3 and 6. Reserved read bits stay zero. Only the bench scenarios can show the mapping itself: which bit and which vector belongs to which source, the priority order among mixed pending sets, and that an acknowledge clears exactly one flag and leaves the others in place.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int NSRC = 4;
    localparam int DW   = 8;
    localparam int VW   = 3;
    localparam int VEC_BASE = 3;

    // source index doubles as priority rank: lower index, lower vector
    typedef enum logic [1:0] {
        SRC_CAP  = 2'd0,
        SRC_CMPA = 2'd1,
        SRC_OVF1 = 2'd2,
        SRC_OVF0 = 2'd3
    } src_e;

    typedef enum logic {
        REG_MASK = 1'b0,
        REG_FLAG = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic           wr;
        reg_sel_e       sel;
        logic [DW-1:0]  data;
    } bus_req_t;

    typedef struct packed {
        logic           valid;
        logic [VW-1:0]  vec;
    } grant_t;

    function automatic int bit_pos(input int src);
        case (src)
            0:       return 3;
            1:       return 6;
            2:       return 7;
            default: return 1;
        endcase
    endfunction

    function automatic logic [VW-1:0] vec_of(input int src);
        return VW'(VEC_BASE + src);
    endfunction

    function automatic logic [DW-1:0] live_bits();
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) m[bit_pos(i)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst) set_i |=> flag_o); // R10
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !flag_o); // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst) (!clr_i && !set_i) |=> $stable(flag_o)); // R9
endmodule

// File: rtl/tmr_mask_reg.sv
module tmr_mask_reg
    import tmr_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_i,
    input  logic [DW-1:0]  wdata_i,
    output logic [DW-1:0]  mask_o,
    output logic [NSRC-1:0] en_o
);
    localparam logic [DW-1:0] LIVE = live_bits();

    logic [DW-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (wr_i) mask_q <= wdata_i & LIVE;
    end

    assign mask_o = mask_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_en
        assign en_o[i] = mask_q[bit_pos(i)];
    end

    AST_MASK_RESV: assert property (@(posedge clk) disable iff (rst) (mask_o & ~LIVE) == '0); // R4
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb
    import tmr_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            gie_i,
    input  logic [NSRC-1:0] flag_i,
    input  logic [NSRC-1:0] en_i,
    output grant_t          grant_o
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] onehot;

    assign pend = gie_i ? (flag_i & en_i) : '0;

    always_comb begin
        onehot = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) onehot = NSRC'(1) << i;
        end
    end

    always_comb begin
        grant_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (onehot[i]) begin
                grant_o.valid = 1'b1;
                grant_o.vec   = vec_of(i);
            end
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst) $onehot0(onehot)); // R8
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ev_cap,
    input  logic           ev_cmpa,
    input  logic           ev_ovf1,
    input  logic           ev_ovf0,
    input  logic           bus_wr,
    input  logic           bus_sel,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    input  logic           gie,
    input  logic           ack_valid,
    input  logic [2:0]     ack_vec,
    output logic           irq_req,
    output logic [2:0]     irq_vec
);
    localparam logic [DW-1:0] LIVE = live_bits();

    bus_req_t        breq;
    logic [NSRC-1:0] ev;
    logic [NSRC-1:0] flag;
    logic [NSRC-1:0] en;
    logic [DW-1:0]   mask_rd;
    logic [DW-1:0]   flag_rd;
    grant_t          grant;

    assign breq.wr   = bus_wr;
    assign breq.sel  = reg_sel_e'(bus_sel);
    assign breq.data = bus_wdata;

    assign ev[SRC_CAP]  = ev_cap;
    assign ev[SRC_CMPA] = ev_cmpa;
    assign ev[SRC_OVF1] = ev_ovf1;
    assign ev[SRC_OVF0] = ev_ovf0;

    tmr_mask_reg u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (breq.wr && breq.sel == REG_MASK),
        .wdata_i (breq.data),
        .mask_o  (mask_rd),
        .en_o    (en)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic wclr;
        logic aclr;
        assign wclr = breq.wr && breq.sel == REG_FLAG && breq.data[bit_pos(i)];
        assign aclr = ack_valid && ack_vec == vec_of(i);
        tmr_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (ev[i]),
            .clr_i  (wclr || aclr),
            .flag_o (flag[i])
        );
    end

    always_comb begin
        flag_rd = '0;
        for (int i = 0; i < NSRC; i++) flag_rd[bit_pos(i)] = flag[i];
    end

    assign bus_rdata = (breq.sel == REG_FLAG) ? flag_rd : mask_rd;

    tmr_irq_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .gie_i   (gie),
        .flag_i  (flag),
        .en_i    (en),
        .grant_o (grant)
    );

    assign irq_req = grant.valid;
    assign irq_vec = grant.vec;

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst) irq_req |-> gie); // R6
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst) irq_req |-> (irq_vec >= 3'd3 && irq_vec <= 3'd6)); // R7
    AST_RDATA_RESV: assert property (@(posedge clk) disable iff (rst) (bus_rdata & ~LIVE) == '0); // R4
    AST_IDLE_VEC: assert property (@(posedge clk) disable iff (rst) !irq_req |-> irq_vec == '0); // R6
endmodule

// File: tb/sim_tmr_irq_ctrl.sv
module sim_tmr_irq_ctrl;
    logic       clk = 0;
    logic       rst = 1;
    logic       ev_cap = 0, ev_cmpa = 0, ev_ovf1 = 0, ev_ovf0 = 0;
    logic       bus_wr = 0, bus_sel = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       gie = 0, ack_valid = 0;
    logic [2:0] ack_vec = 0;
    logic       irq_req;
    logic [2:0] irq_vec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tmr_irq_ctrl u0 (
        .clk(clk), .rst(rst),
        .ev_cap(ev_cap), .ev_cmpa(ev_cmpa), .ev_ovf1(ev_ovf1), .ev_ovf0(ev_ovf0),
        .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gie(gie), .ack_valid(ack_valid), .ack_vec(ack_vec),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // entry: {ev[3:0] = ovf0,ovf1,cmpa,cap ; mask ; gie ; exp_req ; exp_vec}
    localparam int NV = 12;
    localparam logic [16:0] TBL [NV] = '{
        {4'b0001, 8'h08, 1'b1, 1'b1, 3'd3},
        {4'b0010, 8'h40, 1'b1, 1'b1, 3'd4},
        {4'b0100, 8'h80, 1'b1, 1'b1, 3'd5},
        {4'b1000, 8'h02, 1'b1, 1'b1, 3'd6},
        {4'b1111, 8'hCA, 1'b1, 1'b1, 3'd3},
        {4'b1110, 8'hCA, 1'b1, 1'b1, 3'd4},
        {4'b1100, 8'hCA, 1'b1, 1'b1, 3'd5},
        {4'b1111, 8'hC2, 1'b1, 1'b1, 3'd4},
        {4'b1111, 8'hCA, 1'b0, 1'b0, 3'd0},
        {4'b1111, 8'h00, 1'b1, 1'b0, 3'd0},
        {4'b0001, 8'h02, 1'b1, 1'b0, 3'd0},
        {4'b1001, 8'h0A, 1'b1, 1'b1, 3'd3}
    };

    function automatic logic [7:0] flags_of(input logic [3:0] e);
        logic [7:0] f;
        f = 8'h00;
        f[3] = e[0];
        f[6] = e[1];
        f[7] = e[2];
        f[1] = e[3];
        return f;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic sel, input logic [7:0] d);
        bus_sel = sel; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic pulse(input logic [3:0] e);
        {ev_ovf0, ev_ovf1, ev_cmpa, ev_cap} = e;
        @(negedge clk);
        {ev_ovf0, ev_ovf1, ev_cmpa, ev_cap} = 4'b0;
    endtask

    task automatic rreg(input logic sel, output logic [7:0] d);
        bus_sel = sel;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        rreg(1'b1, rd); chk("R1 flags", rd, 8'h00);
        rreg(1'b0, rd); chk("R1 mask", rd, 8'h00);
        chk("R1 irq_req", irq_req, 1'b0);

        // vector table walk (R2, R6, R7, R8)
        for (int k = 0; k < NV; k++) begin
            logic [3:0] e;
            logic [7:0] m;
            logic g, xr;
            logic [2:0] xv;
            {e, m, g, xr, xv} = TBL[k];
            gie = 0;
            wreg(1'b1, 8'hFF);
            wreg(1'b0, m);
            pulse(e);
            gie = g;
            #1;
            chk("R6 irq_req", irq_req, xr);
            chk("R8 irq_vec", irq_vec, xv);
            rreg(1'b1, rd); chk("R2 flag bits", rd, flags_of(e));
        end

        // R4 / R5: reserved mask bits
        gie = 0;
        wreg(1'b0, 8'hFF);
        rreg(1'b0, rd); chk("R4 mask reserved", rd, 8'hCA);
        wreg(1'b0, 8'h35);
        rreg(1'b0, rd); chk("R5 mask store", rd, 8'h00);
        wreg(1'b0, 8'h48);
        rreg(1'b0, rd); chk("R5 mask readback", rd, 8'h48);

        // R3: write zero keeps, write one clears
        pulse(4'b1111);
        wreg(1'b1, 8'h00);
        rreg(1'b1, rd); chk("R3 write zero", rd, 8'hCA);
        wreg(1'b1, 8'h35);
        rreg(1'b1, rd); chk("R4 flag reserved", rd, 8'hCA);
        wreg(1'b1, 8'h08);
        rreg(1'b1, rd); chk("R3 clear one", rd, 8'hC2);

        // R9: ack clears only the matching flag
        pulse(4'b1111);
        ack_vec = 3'd4; ack_valid = 1;
        @(negedge clk); ack_valid = 0;
        rreg(1'b1, rd); chk("R9 ack vec4", rd, 8'h8A);
        ack_vec = 3'd7; ack_valid = 1;
        @(negedge clk); ack_valid = 0;
        rreg(1'b1, rd); chk("R9 ack unmatched", rd, 8'h8A);
        ack_vec = 3'd6; ack_valid = 1;
        @(negedge clk); ack_valid = 0;
        rreg(1'b1, rd); chk("R9 ack vec6", rd, 8'h88);

        // R10: event wins over clear
        bus_sel = 1; bus_wdata = 8'hC0; bus_wr = 1; ev_cmpa = 1;
        @(negedge clk);
        bus_wr = 0; ev_cmpa = 0; bus_wdata = 0;
        rreg(1'b1, rd); chk("R10 event vs write", rd, 8'h48);
        ack_vec = 3'd3; ack_valid = 1; ev_cap = 1;
        @(negedge clk);
        ack_valid = 0; ev_cap = 0;
        rreg(1'b1, rd); chk("R10 event vs ack", rd, 8'h48);

        // R6: gie gating at the output, with mask 0x48
        gie = 1; #1;
        chk("R6 gie on", irq_req, 1'b1);
        chk("R7 capture vector", irq_vec, 3'd3);
        gie = 0; #1;
        chk("R6 gie off", irq_req, 1'b0);

        // R1: reset clears populated state
        rst = 1; @(negedge clk); rst = 0;
        rreg(1'b1, rd); chk("R1 flags after reset", rd, 8'h00);
        rreg(1'b0, rd); chk("R1 mask after reset", rd, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule